// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one serial flash command at a time on behalf of a host that talks to it through a 32-bit register port. The host first fills a command register (the command byte plus a 24-bit flash address) and, when needed, a data register. It then writes the control register with a transmit byte count, a receive byte count and the start bit. The engine selects the flash and clocks the command out in SPI mode 0. Any reply bytes are collected into the data register. The host polls a busy flag until the engine is idle again.

Up to eight bytes are sent in one transaction. The first four come from the command register and the next four from the data register, lowest byte first. A page program of one to four data bytes therefore needs only one transaction. Up to four bytes are received. The serial clock is the system clock divided by a parameter.

Top module: `sfc_engine`

## Requirements
- R1: After reset all three registers read zero, chip select is high, SCK is low and MOSI is low.
- R2: Register map by `reg_addr`. 0 is control: transmit count in bits 3:0, receive count in bits 7:4, start in bit 8 (write only), busy in bit 16 (read only). 1 is command: command byte in bits 7:0, address in bits 31:8. 2 is data. Written values read back.
- R3: A control write with start set and a transmit count of 1 to 8 while idle reads busy=1 in the next cycle. Chip select stays low for the whole transaction, and only one chip-select pulse is produced.
- R4: Transmit bytes go out in this order: command bits 7:0, then address bits 31:24, 23:16 and 15:8, then data bits 7:0, 15:8, 23:16 and 31:24. Each byte is sent MSB first.
- R5: SPI mode 0. SCK idles low whenever chip select is high. MOSI never changes while SCK is high. MISO is sampled on the SCK rising edge. Each SCK high phase lasts SCK_HALF_DIV system clocks.
- R6: Receive bytes follow the transmit bytes, with MOSI held at 0. The first received byte lands in data bits 7:0 and the next ones in ascending bytes. Bytes above the receive count read zero. A receive count above 4 acts as 4. A receive count of 0 leaves the data register unchanged.
- R7: After the last bit, chip select goes high and busy stays 1 for 2 further SCK periods (4*SCK_HALF_DIV clocks) before it clears.
- R8: While busy, writes to any register are ignored, and that includes a new start.
- R9: A start with a transmit count of 0 or above 8 produces no bus activity, and busy stays 0.
- R10: A transaction carries exactly transmit count plus effective receive count bytes, 8 SCK pulses each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 command, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The checker watches a set of rules on every cycle. SCK stays low while the flash is deselected, and MOSI does not move while SCK is high. A valid start raises busy on the next cycle and an invalid one does not. The command register holds still while busy, chip select rises only while busy is still set, and a one-byte reply leaves the upper data bytes at zero. Other properties need the bench's flash model that responds on the wire. These are the byte order on the wire, the placement of the received bytes, the exact byte count per transaction, the deselect gap before busy clears, and the loss of a start issued while busy.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int TX_MAX   = 8;
    localparam int RX_MAX   = 4;
    localparam int CW       = 4;
    localparam int RXW      = 3;
    localparam int GAP_TICKS = 4;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CMD  = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam int START_BIT = 8;
    localparam int BUSY_BIT  = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e   st;
        logic [CW-1:0] byte_idx;
        logic [2:0]   bit_idx;
        logic [7:0]   sh;
        logic [31:0]  acc;
        logic [1:0]   gap;
        logic         sck;
        logic         cs_n;
        logic         mosi;
        logic [CW-1:0] tx;
        logic [CW-1:0] total;
    } seq_t;

    typedef struct packed {
        logic [31:0]   cmd;
        logic [31:0]   data;
        logic [CW-1:0] tx;
        logic [RXW-1:0] rx;
    } regs_t;
endpackage

// File: rtl/sfc_sck_div.sv
module sfc_sck_div #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(HALF_DIV - 1);

    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sfc_tx_mux.sv
module sfc_tx_mux (
    input  logic [31:0] cmd,
    input  logic [31:0] data,
    input  logic [3:0]  idx,
    output logic [7:0]  tx_byte
);
    always_comb begin
        case (idx)
            4'd0:    tx_byte = cmd[7:0];
            4'd1:    tx_byte = cmd[31:24];
            4'd2:    tx_byte = cmd[23:16];
            4'd3:    tx_byte = cmd[15:8];
            4'd4:    tx_byte = data[7:0];
            4'd5:    tx_byte = data[15:8];
            4'd6:    tx_byte = data[23:16];
            4'd7:    tx_byte = data[31:24];
            default: tx_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
    import sfc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch,
    input  logic [CW-1:0]  tx_cnt,
    input  logic [RXW-1:0] rx_cnt,
    input  logic           tick,
    input  logic [31:0]    cmd,
    input  logic [31:0]    data,
    input  logic           miso,
    output logic           busy,
    output logic           cs_n,
    output logic           sck,
    output logic           mosi,
    output logic           finish,
    output logic [31:0]    rx_word
);
    seq_t q, d;
    logic [CW-1:0] sel;
    logic [7:0]    mux_byte;
    logic [7:0]    next_byte;
    logic [CW-1:0] rx_pos;

    sfc_tx_mux u_mux (
        .cmd     (cmd),
        .data    (data),
        .idx     (sel),
        .tx_byte (mux_byte)
    );

    always_comb begin
        sel       = launch ? '0 : q.byte_idx + 1'b1;
        next_byte = (sel < (launch ? tx_cnt : q.tx)) ? mux_byte : 8'h00;
        rx_pos    = q.byte_idx - q.tx;
        d         = q;
        finish    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (launch) begin
                    d.st       = ST_SHIFT;
                    d.byte_idx = '0;
                    d.bit_idx  = 3'd7;
                    d.sh       = next_byte;
                    d.mosi     = next_byte[7];
                    d.cs_n     = 1'b0;
                    d.sck      = 1'b0;
                    d.acc      = '0;
                    d.tx       = tx_cnt;
                    d.total    = tx_cnt + CW'(rx_cnt);
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!q.sck) begin
                        d.sck = 1'b1;
                        if (q.byte_idx >= q.tx)
                            d.acc[{rx_pos[1:0], q.bit_idx}] = miso;
                    end else begin
                        d.sck = 1'b0;
                        if (q.bit_idx == 3'd0) begin
                            if (q.byte_idx == q.total - 1'b1) begin
                                d.st   = ST_GAP;
                                d.cs_n = 1'b1;
                                d.mosi = 1'b0;
                                d.gap  = '0;
                            end else begin
                                d.byte_idx = q.byte_idx + 1'b1;
                                d.bit_idx  = 3'd7;
                                d.sh       = next_byte;
                                d.mosi     = next_byte[7];
                            end
                        end else begin
                            d.bit_idx = q.bit_idx - 3'd1;
                            d.mosi    = q.sh[q.bit_idx - 3'd1];
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (q.gap == 2'(GAP_TICKS - 1)) begin
                        d.st   = ST_IDLE;
                        finish = 1'b1;
                    end else begin
                        d.gap = q.gap + 2'd1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign cs_n    = q.cs_n;
    assign sck     = q.sck;
    assign mosi    = q.mosi;
    assign rx_word = q.acc;
endmodule

// File: rtl/sfc_engine.sv
module sfc_engine
    import sfc_pkg::*;
#(
    parameter int SCK_HALF_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    regs_t          q, d;
    logic           busy, tick, finish, launch, wr_ok;
    logic [CW-1:0]  wr_tx;
    logic [RXW-1:0] wr_rx;
    logic [31:0]    rx_word;
    logic [31:0]    cmd_reg, data_reg;
    logic [RXW-1:0] rx_reg;

    always_comb begin
        wr_ok  = reg_wr && !busy;
        wr_tx  = reg_wdata[3:0];
        wr_rx  = (reg_wdata[7:4] > 4'(RX_MAX)) ? RXW'(RX_MAX) : reg_wdata[6:4];
        launch = wr_ok && (reg_addr == A_CTRL) && reg_wdata[START_BIT]
                 && (wr_tx != '0) && (wr_tx <= CW'(TX_MAX));
        d = q;
        if (wr_ok) begin
            case (reg_addr)
                A_CTRL: begin
                    d.tx = wr_tx;
                    d.rx = wr_rx;
                end
                A_CMD:   d.cmd  = reg_wdata;
                A_DATA:  d.data = reg_wdata;
                default: ;
            endcase
        end
        if (finish && (q.rx != '0)) d.data = rx_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {15'd0, busy, 8'd0, 1'b0, q.rx, q.tx};
            A_CMD:   reg_rdata = q.cmd;
            A_DATA:  reg_rdata = q.data;
            default: reg_rdata = 32'd0;
        endcase
    end

    assign cmd_reg  = q.cmd;
    assign data_reg = q.data;
    assign rx_reg   = q.rx;

    sfc_sck_div #(.HALF_DIV(SCK_HALF_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    sfc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .tx_cnt  (wr_tx),
        .rx_cnt  (wr_rx),
        .tick    (tick),
        .cmd     (q.cmd),
        .data    (q.data),
        .miso    (spi_miso),
        .busy    (busy),
        .cs_n    (spi_cs_n),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .finish  (finish),
        .rx_word (rx_word)
    );
endmodule

// File: rtl/sfc_engine_chk.sv
module sfc_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        spi_cs_n,
    input logic        spi_sck,
    input logic        spi_mosi,
    input logic        busy,
    input logic [31:0] cmd_reg,
    input logic [31:0] data_reg,
    input logic [2:0]  rx_reg
);
    a_r5_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    a_r5_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sck |-> $stable(spi_mosi));

    a_r3_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[8] && !busy
         && reg_wdata[3:0] != 4'd0 && reg_wdata[3:0] <= 4'd8) |=> (busy && !spi_cs_n));

    a_r3_cs_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    a_r9_bad_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && reg_wdata[8] && !busy
         && (reg_wdata[3:0] == 4'd0 || reg_wdata[3:0] > 4'd8)) |=> (!busy && spi_cs_n));

    a_r8_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == 2'd1) |=> $stable(cmd_reg));

    a_r7_busy_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> busy);

    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && rx_reg == 3'd1) |-> (data_reg[31:8] == 24'd0));
endmodule

bind sfc_engine sfc_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .busy      (busy),
    .cmd_reg   (cmd_reg),
    .data_reg  (data_reg),
    .rx_reg    (rx_reg)
);

// File: tb/sim_sfc_engine.sv
`timescale 1ns/1ps
module sim_sfc_engine;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int cs_falls = 0;
    int cs_rise_cyc = 0;
    int hi_cyc = 0;
    int half_viol = 0;
    int idle_viol = 0;
    int mosi_viol = 0;
    int nbits = 0;
    logic [7:0] sh = 8'd0;
    logic [7:0] got_q[$];
    logic       miso_q[$];
    logic       prev_mosi = 1'b0;
    logic       prev_sck = 1'b0;
    bit         finished = 0;

    sfc_engine #(.SCK_HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #5 clk = ~clk;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (spi_cs_n && spi_sck) idle_viol++;
            if (spi_sck && prev_sck && spi_mosi != prev_mosi) mosi_viol++;
        end
        prev_mosi <= spi_mosi;
        prev_sck  <= spi_sck;
    end

    function automatic logic next_miso();
        if (miso_q.size() > 0) return miso_q.pop_front();
        return 1'b0;
    endfunction

    // flash model: shifts in on rising SCK, drives reply on falling SCK
    always @(negedge spi_cs_n) begin
        if (rst_n) begin
            cs_falls++;
            nbits = 0;
            spi_miso = next_miso();
        end
    end
    always @(posedge spi_cs_n) cs_rise_cyc = cyc;
    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            sh = {sh[6:0], spi_mosi};
            nbits++;
            if (nbits % 8 == 0) got_q.push_back(sh);
            hi_cyc = cyc;
        end
    end
    always @(negedge spi_sck) begin
        if (!spi_cs_n) begin
            if (cyc - hi_cyc != HALF) half_viol++;
            spi_miso = next_miso();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle(output int idle_at);
        logic [31:0] v;
        idle_at = -1;
        for (int i = 0; i < 5000; i++) begin
            reg_read(2'd0, v);
            if (!v[16]) begin idle_at = cyc; break; end
        end
    endtask

    function automatic logic [7:0] exp_tx(input logic [31:0] c, input logic [31:0] d, input int k);
        case (k)
            0: return c[7:0];
            1: return c[31:24];
            2: return c[23:16];
            3: return c[15:8];
            default: return d[8*(k-4) +: 8];
        endcase
    endfunction

    task automatic run_txn(input string tag, input logic [31:0] c, input logic [31:0] d,
                           input int tx, input int rx, input logic [31:0] reply);
        logic [31:0] v, exp_d;
        int rx_eff, falls0, idle_at;
        rx_eff = (rx > 4) ? 4 : rx;
        got_q.delete();
        miso_q.delete();
        for (int i = 0; i < tx * 8; i++) miso_q.push_back(1'b0);
        for (int j = 0; j < rx_eff; j++)
            for (int b = 7; b >= 0; b--) miso_q.push_back(reply[8*j + b]);
        reg_write(2'd1, c);
        reg_write(2'd2, d);
        falls0 = cs_falls;
        reg_write(2'd0, 32'h100 | (32'(rx) << 4) | 32'(tx));
        reg_read(2'd0, v);
        chk({"R3 busy after start ", tag}, {31'd0, v[16]}, 32'd1);
        wait_idle(idle_at);
        chk({"R3 single cs pulse ", tag}, cs_falls - falls0, 32'd1);
        chk({"R7 deselect gap ", tag}, {31'd0, (idle_at - cs_rise_cyc) >= 4 * HALF}, 32'd1);
        chk({"R10 byte count ", tag}, got_q.size(), tx + rx_eff);
        for (int k = 0; k < tx && k < got_q.size(); k++)
            chk($sformatf("R4 tx byte %0d %s", k, tag), {24'd0, got_q[k]}, {24'd0, exp_tx(c, d, k)});
        for (int k = tx; k < got_q.size(); k++)
            chk($sformatf("R6 mosi zero in rx byte %0d %s", k, tag), {24'd0, got_q[k]}, 32'd0);
        exp_d = d;
        if (rx_eff > 0) begin
            exp_d = 32'd0;
            for (int j = 0; j < rx_eff; j++) exp_d[8*j +: 8] = reply[8*j +: 8];
        end
        reg_read(2'd2, v);
        chk({"R6 data register ", tag}, v, exp_d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int f0, idle_at;
        repeat (3) @(negedge clk);
        // R1 reset state
        reg_read(2'd0, v); chk("R1 ctrl reset", v, 32'd0);
        reg_read(2'd1, v); chk("R1 cmd reset", v, 32'd0);
        reg_read(2'd2, v); chk("R1 data reset", v, 32'd0);
        chk("R1 pins reset", {29'd0, spi_cs_n, spi_sck, spi_mosi}, 32'b100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 register readback
        reg_write(2'd1, 32'hCAFE_1234); reg_read(2'd1, v); chk("R2 cmd readback", v, 32'hCAFE_1234);
        reg_write(2'd2, 32'h0BAD_F00D); reg_read(2'd2, v); chk("R2 data readback", v, 32'h0BAD_F00D);
        reg_write(2'd0, 32'h0000_0025); reg_read(2'd0, v); chk("R2 ctrl counts", v, 32'h0000_0025);

        run_txn("write-enable", 32'h0000_0006, 32'h1111_2222, 1, 0, 32'd0);
        run_txn("status", 32'h0000_0005, 32'h5555_5555, 1, 1, 32'hFFFF_FFA5);
        run_txn("erase", 32'h1234_56D8, 32'd0, 4, 0, 32'd0);
        run_txn("signature", 32'h0000_00AB, 32'h7777_7777, 4, 1, 32'h0000_0013);
        run_txn("page-3", 32'hABCD_EF02, 32'h4433_2211, 7, 0, 32'd0);
        run_txn("page-4", 32'h0010_2002, 32'h8877_6655, 8, 0, 32'd0);
        run_txn("read-4", 32'h0000_0003, 32'd0, 4, 4, 32'hC3B2_A190);
        run_txn("rx-clamp", 32'h0000_009F, 32'd0, 1, 6, 32'h0102_0304);

        // R9 bad transmit counts
        f0 = cs_falls;
        reg_write(2'd0, 32'h0000_0100);
        reg_read(2'd0, v); chk("R9 tx0 no busy", {31'd0, v[16]}, 32'd0);
        reg_write(2'd0, 32'h0000_0109);
        reg_read(2'd0, v); chk("R9 tx9 no busy", {31'd0, v[16]}, 32'd0);
        repeat (20) @(negedge clk);
        chk("R9 no bus activity", cs_falls - f0, 32'd0);

        // R8 writes while busy ignored
        reg_write(2'd1, 32'h0302_0106);
        reg_write(2'd2, 32'h0A0B_0C0D);
        f0 = cs_falls;
        got_q.delete(); miso_q.delete();
        reg_write(2'd0, 32'h0000_0108);
        reg_write(2'd1, 32'hDEAD_BEEF);
        reg_write(2'd2, 32'h1234_5678);
        reg_write(2'd0, 32'h0000_0111);
        wait_idle(idle_at);
        reg_read(2'd1, v); chk("R8 cmd kept", v, 32'h0302_0106);
        reg_read(2'd2, v); chk("R8 data kept", v, 32'h0A0B_0C0D);
        reg_read(2'd0, v); chk("R8 counts kept", v, 32'h0000_0008);
        chk("R8 start ignored", cs_falls - f0, 32'd1);
        chk("R8 byte count", got_q.size(), 32'd8);
        repeat (20) @(negedge clk);
        chk("R8 no later txn", cs_falls - f0, 32'd1);

        // R5 aggregated mode-0 observations
        chk("R5 sck high phase length", half_viol, 32'd0);
        chk("R5 sck idle low", idle_viol, 32'd0);
        chk("R5 mosi steady while sck high", mosi_viol, 32'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule